// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block is the bookkeeping for a single line of a memory-side coherence directory. A full presence bit vector would cost one bit per node. Instead, the entry keeps a small, fixed number of node-id pointers. While the number of sharers fits in those pointers, the entry knows each sharer exactly. When a new sharer arrives and every pointer is already in use, the entry follows one of three overflow policies, chosen at build time:

- **Broadcast:** the entry raises an overflow flag. The next write then invalidates every node.
- **Evict:** the entry never holds more sharers than it has pointers. A newcomer takes over the pointer slot picked by a round-robin victim index, and the displaced node is invalidated at once.
- **Coarse:** the pointer storage bits are reused as a vector of group bits. Each group bit stands for a run of consecutive nodes.

Commands come one per cycle:

- **Add a sharer:** a read miss has been granted.
- **Drop a sharer:** a replacement hint has arrived.
- **Write:** a write or ownership request from a node.

A write returns the set of nodes that must be invalidated, with the writer left out. After a write, the entry holds only the writer, in exact pointer form. All results are registered and appear one cycle after the command that caused them.

Top module: `ldir_entry`

## Requirements
- R1: After synchronous reset, every output is low, the entry holds no sharers, and the round-robin victim index points at slot 0.
- R2: Outputs are registered. The results of a command sampled at a rising edge are visible from that edge until the next one. An idle cycle (cmdValid low, or cmdOp=3), or a drop command, never raises invValid.
- R3: Commands are encoded on cmdOp as follows: 0 = add, 1 = drop, 2 = write, 3 = idle. While no overflow has occurred, up to PTRS distinct sharers are kept exactly, and adding a node that is already recorded changes nothing. A write raises invValid for one cycle, with invMask holding exactly the recorded sharers minus the writer.
- R4: In exact pointer form, a drop clears the pointer that holds that node. A drop of a node that is not recorded has no effect, which a later write's invMask shows.
- R5: In broadcast policy (OVF_MODE=0), an add to a full entry of a new node sets overflow. The next write then raises invAll together with an invMask of all nodes except the writer.
- R6: In evict policy (OVF_MODE=1), an add to a full entry of a new node replaces the pointer in the victim slot. The victim slot starts at slot 0 and advances by one, modulo PTRS, on every displacement. One cycle later the outputs show invValid=1, evictValid=1, evictNode=the displaced node, and invMask with only that node's bit set. The entry never records more than PTRS sharers.
- R7: In coarse policy (OVF_MODE=2), an add to a full entry of a new node turns the storage into a group vector. Group g covers nodes g*GRP to g*GRP+GRP-1, with GRP=2 and 8 groups at the defaults. The groups of all recorded pointers and of the new node are set. Later adds set their own group, and no add raises invValid.
- R8: In coarse policy after overflow, a write's invMask holds every node of every set group, minus the writer.
- R9: Once overflow has occurred, in broadcast or coarse policy, drop commands are ignored, and the next write's target is unchanged by them.
- R10: A write returns the entry to exact pointer form holding only the writer. A write by another node in the next command therefore targets only the previous writer.
- R11: The writer's own bit is never set in a write's invMask. invAll is raised only in broadcast policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 add, 1 drop, 2 write, 3 idle |
| cmdNode | input | $clog2(NODES) | Node id of the requester |
| invValid | output | 1 | Invalidation set is valid this cycle |
| invMask | output | NODES | Nodes to invalidate, bit n = node n |
| invAll | output | 1 | Broadcast invalidation after overflow |
| evictValid | output | 1 | A sharer was displaced (evict policy) |
| evictNode | output | $clog2(NODES) | Id of the displaced sharer |

## Verification
The assertions take these things for granted about the inputs:
- Exactly one command is presented per cycle, and each command is fully described by cmdOp and cmdNode.
- Every node id names a real node. This holds automatically because NODES is a power of two.
- Reset is held for at least one edge before any command.

The stimulus keeps within these limits in two ways:
- It drives all inputs on the falling clock edge and releases reset before the first command.
- It draws node ids only from 0 to NODES-1. It biases the random phase toward adds, so that all three policies reach overflow, displacement and group marking repeatedly between writes.

// File: rtl/ldir_pkg.sv
package ldir_pkg;

  localparam int OVF_BCAST  = 0;
  localparam int OVF_EVICT  = 1;
  localparam int OVF_COARSE = 2;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_DROP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_IDLE  = 2'd3
  } dirOp_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic fillFree;
    logic replaceVictim;
    logic goCoarse;
    logic markGroup;
    logic goBcast;
    logic dropMatch;
    logic issueWrite;
  } dirStrobe_t;

  typedef struct packed {
    logic ovf;
    logic hit;
    logic full;
  } dirStatus_t;

  // smallest power-of-two group such that the group vector fits the pointer bits
  function automatic int groupSize(input int nodes, input int storeBits);
    int g;
    g = 1;
    while ((nodes / g) > storeBits) g = g * 2;
    return g;
  endfunction

endpackage

// File: rtl/ldir_ctrl.sv
module ldir_ctrl
  import ldir_pkg::*;
#(
  parameter int PTRS     = 2,
  parameter int OVF_MODE = OVF_COARSE,
  parameter int VW       = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  dirStatus_t    status,
  output dirStrobe_t    strobe,
  output logic [VW-1:0] victimIdx
);

  logic [VW-1:0] rrIdx;

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      case (dirOp_e'(cmdOp))
        OP_ADD: begin
          if (status.ovf) begin
            strobe.markGroup = (OVF_MODE == OVF_COARSE);
          end else if (!status.hit) begin
            if (!status.full)                strobe.fillFree      = 1'b1;
            else if (OVF_MODE == OVF_EVICT)  strobe.replaceVictim = 1'b1;
            else if (OVF_MODE == OVF_COARSE) strobe.goCoarse      = 1'b1;
            else                             strobe.goBcast       = 1'b1;
          end
        end
        OP_DROP:  strobe.dropMatch  = !status.ovf && status.hit;
        OP_WRITE: strobe.issueWrite = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrIdx <= '0;
    end else if (strobe.replaceVictim) begin
      rrIdx <= (rrIdx == VW'(PTRS - 1)) ? '0 : rrIdx + 1'b1;
    end
  end

  assign victimIdx = rrIdx;

endmodule

// File: rtl/ldir_dp.sv
module ldir_dp
  import ldir_pkg::*;
#(
  parameter int NODES    = 16,
  parameter int PTRS     = 2,
  parameter int OVF_MODE = OVF_COARSE,
  parameter int NW       = $clog2(NODES),
  parameter int VW       = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  dirStrobe_t       strobe,
  input  logic [VW-1:0]    victimIdx,
  input  logic [NW-1:0]    cmdNode,
  output dirStatus_t       status,
  output logic             invValid,
  output logic [NODES-1:0] invMask,
  output logic             invAll,
  output logic             evictValid,
  output logic [NW-1:0]    evictNode
);

  localparam int STW = PTRS * NW;
  localparam int GRP = groupSize(NODES, STW);
  localparam int GSH = $clog2(GRP);
  localparam int CVW = NODES / GRP;
  localparam int GW  = (CVW > 1) ? $clog2(CVW) : 1;

  // one word: pointer slots in exact form, group vector after coarse overflow
  logic [STW-1:0]   store;
  logic [PTRS-1:0]  ptrVld;
  logic             ovf;

  logic [NW-1:0]    slotNode [PTRS];
  logic [PTRS-1:0]  slotHit;
  logic [VW-1:0]    freeIdx, hitIdx;
  logic [NODES-1:0] ptrMask, ovfMask, writerBit, targets;
  logic [CVW-1:0]   cvNew;

  function automatic logic [GW-1:0] grpOf(input logic [NW-1:0] n);
    return GW'(n >> GSH);
  endfunction

  for (genvar k = 0; k < PTRS; k++) begin : g_slot
    assign slotNode[k] = store[k*NW +: NW];
    assign slotHit[k]  = ptrVld[k] && (slotNode[k] == cmdNode);
  end

  always_comb begin
    freeIdx = '0;
    hitIdx  = '0;
    for (int k = PTRS - 1; k >= 0; k--) begin
      if (!ptrVld[k]) freeIdx = VW'(k);
      if (slotHit[k]) hitIdx  = VW'(k);
    end
  end

  always_comb begin
    ptrMask = '0;
    for (int k = 0; k < PTRS; k++)
      if (ptrVld[k]) ptrMask[slotNode[k]] = 1'b1;
  end

  always_comb begin
    cvNew = '0;
    for (int k = 0; k < PTRS; k++)
      if (ptrVld[k]) cvNew[grpOf(slotNode[k])] = 1'b1;
    cvNew[grpOf(cmdNode)] = 1'b1;
  end

  if (OVF_MODE == OVF_COARSE) begin : g_coarse
    for (genvar n = 0; n < NODES; n++) begin : g_node
      assign ovfMask[n] = store[n >> GSH];
    end
  end else begin : g_flat
    assign ovfMask = '1;
  end

  assign writerBit = NODES'(1) << cmdNode;
  assign targets   = (ovf ? ovfMask : ptrMask) & ~writerBit;

  always_comb begin
    status.ovf  = ovf;
    status.hit  = |slotHit;
    status.full = &ptrVld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store      <= '0;
      ptrVld     <= '0;
      ovf        <= 1'b0;
      invValid   <= 1'b0;
      invMask    <= '0;
      invAll     <= 1'b0;
      evictValid <= 1'b0;
      evictNode  <= '0;
    end else begin
      invValid   <= 1'b0;
      invMask    <= '0;
      invAll     <= 1'b0;
      evictValid <= 1'b0;
      evictNode  <= '0;

      if (strobe.fillFree) begin
        for (int k = 0; k < PTRS; k++) begin
          if (VW'(k) == freeIdx) begin
            store[k*NW +: NW] <= cmdNode;
            ptrVld[k]         <= 1'b1;
          end
        end
      end

      if (strobe.replaceVictim) begin
        for (int k = 0; k < PTRS; k++) begin
          if (VW'(k) == victimIdx) begin
            store[k*NW +: NW] <= cmdNode;
            evictValid        <= 1'b1;
            evictNode         <= slotNode[k];
            invValid          <= 1'b1;
            invMask           <= NODES'(1) << slotNode[k];
          end
        end
      end

      if (strobe.goCoarse) begin
        store  <= STW'(cvNew);
        ptrVld <= '0;
        ovf    <= 1'b1;
      end

      if (strobe.markGroup) store[grpOf(cmdNode)] <= 1'b1;

      if (strobe.goBcast) ovf <= 1'b1;

      if (strobe.dropMatch) begin
        for (int k = 0; k < PTRS; k++)
          if (VW'(k) == hitIdx) ptrVld[k] <= 1'b0;
      end

      if (strobe.issueWrite) begin
        invValid <= 1'b1;
        invMask  <= targets;
        invAll   <= ovf && (OVF_MODE == OVF_BCAST);
        store    <= STW'(cmdNode);
        ptrVld   <= PTRS'(1);
        ovf      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ldir_entry.sv
module ldir_entry
  import ldir_pkg::*;
#(
  parameter int NODES    = 16,
  parameter int PTRS     = 2,
  parameter int OVF_MODE = OVF_COARSE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmdValid,
  input  logic [1:0]               cmdOp,
  input  logic [$clog2(NODES)-1:0] cmdNode,
  output logic                     invValid,
  output logic [NODES-1:0]         invMask,
  output logic                     invAll,
  output logic                     evictValid,
  output logic [$clog2(NODES)-1:0] evictNode
);

  localparam int NW = $clog2(NODES);
  localparam int VW = (PTRS > 1) ? $clog2(PTRS) : 1;

  dirStrobe_t    strobe;
  dirStatus_t    status;
  logic [VW-1:0] victimIdx;

  ldir_ctrl #(.PTRS(PTRS), .OVF_MODE(OVF_MODE), .VW(VW)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .status(status), .strobe(strobe), .victimIdx(victimIdx)
  );

  ldir_dp #(.NODES(NODES), .PTRS(PTRS), .OVF_MODE(OVF_MODE), .NW(NW), .VW(VW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .victimIdx(victimIdx), .cmdNode(cmdNode),
    .status(status), .invValid(invValid), .invMask(invMask), .invAll(invAll),
    .evictValid(evictValid), .evictNode(evictNode)
  );

endmodule

// File: rtl/ldir_entry_chk.sv
module ldir_entry_chk
  import ldir_pkg::*;
#(
  parameter int NODES    = 16,
  parameter int PTRS     = 2,
  parameter int OVF_MODE = OVF_COARSE
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmdValid,
  input logic [1:0]               cmdOp,
  input logic [$clog2(NODES)-1:0] cmdNode,
  input logic                     invValid,
  input logic [NODES-1:0]         invMask,
  input logic                     invAll,
  input logic                     evictValid,
  input logic [$clog2(NODES)-1:0] evictNode
);

  a_r11_writer_excluded: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'd2) |=> (invValid && !invMask[$past(cmdNode)]));

  a_r2_quiet_cycle: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdOp == 2'd1 || cmdOp == 2'd3) |=> !invValid);

  a_r11_all_needs_valid: assert property (@(posedge clk) disable iff (rst)
    invAll |-> invValid);

  a_r10_single_writer: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'd2) ##1 (cmdValid && cmdOp == 2'd2) |=>
      (invMask == ((NODES'(1) << $past(cmdNode, 2)) & ~(NODES'(1) << $past(cmdNode)))));

  if (OVF_MODE == OVF_BCAST) begin : g_bc
    a_r5_bcast_mask: assert property (@(posedge clk) disable iff (rst)
      invAll |-> (invMask == ~(NODES'(1) << $past(cmdNode))));
  end else begin : g_nbc
    a_r11_no_all: assert property (@(posedge clk) disable iff (rst) !invAll);
  end

  if (OVF_MODE == OVF_EVICT) begin : g_ev
    a_r6_evict_pair: assert property (@(posedge clk) disable iff (rst)
      evictValid |-> (invValid && !invAll && invMask == (NODES'(1) << evictNode)));
    a_r6_evict_from_add: assert property (@(posedge clk) disable iff (rst)
      evictValid |-> $past(cmdValid && cmdOp == 2'd0));
  end else begin : g_nev
    a_r7_add_silent: assert property (@(posedge clk) disable iff (rst)
      (cmdValid && cmdOp == 2'd0) |=> (!invValid && !evictValid));
  end

endmodule

bind ldir_entry ldir_entry_chk #(.NODES(NODES), .PTRS(PTRS), .OVF_MODE(OVF_MODE)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNode(cmdNode),
  .invValid(invValid), .invMask(invMask), .invAll(invAll),
  .evictValid(evictValid), .evictNode(evictNode)
);

// File: tb/ldir_entry_test.sv
module ldir_entry_test;

  localparam int CLK_PERIOD = 10;
  localparam int NODES      = 16;
  localparam int PTRS       = 2;
  localparam int NW         = 4;
  localparam int GRP        = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd3;
  logic [NW-1:0] cmdNode = '0;

  logic [2:0]       invValidV, invAllV, evictValidV;
  logic [NODES-1:0] invMaskV [3];
  logic [NW-1:0]    evictNodeV [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    ldir_entry #(.NODES(NODES), .PTRS(PTRS), .OVF_MODE(m)) uut (
      .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNode(cmdNode),
      .invValid(invValidV[m]), .invMask(invMaskV[m]), .invAll(invAllV[m]),
      .evictValid(evictValidV[m]), .evictNode(evictNodeV[m])
    );
  end

  int vectors = 0;
  int misses  = 0;

  // behavioural reference, one per policy (0 broadcast, 1 evict, 2 coarse)
  int               sNode [3][PTRS];
  bit               sUsed [3][PTRS];
  bit               mOvf  [3];
  bit [NODES-1:0]   mCov  [3];
  int               mRr   [3];
  bit               eValid[3], eAll[3], eEv[3];
  bit [NODES-1:0]   eMask [3];
  int               eEvN  [3];

  function automatic bit [NODES-1:0] grpMask(input int n);
    bit [NODES-1:0] r;
    int g;
    r = '0;
    g = n / GRP;
    for (int j = 0; j < GRP; j++) r[g*GRP + j] = 1'b1;
    return r;
  endfunction

  task automatic modelReset();
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < PTRS; k++) begin sNode[m][k] = 0; sUsed[m][k] = 0; end
      mOvf[m] = 0; mCov[m] = '0; mRr[m] = 0;
      eValid[m] = 0; eAll[m] = 0; eEv[m] = 0; eMask[m] = '0; eEvN[m] = 0;
    end
  endtask

  task automatic modelStep(input int m, input int op, input int n);
    bit present;
    int freeK;
    bit [NODES-1:0] t;
    eValid[m] = 0; eAll[m] = 0; eEv[m] = 0; eMask[m] = '0; eEvN[m] = 0;
    present = 0; freeK = -1; t = '0;
    case (op)
      0: begin
        for (int k = 0; k < PTRS; k++) if (sUsed[m][k] && sNode[m][k] == n) present = 1;
        for (int k = PTRS - 1; k >= 0; k--) if (!sUsed[m][k]) freeK = k;
        if (mOvf[m]) begin
          if (m == 2) mCov[m] |= grpMask(n);
        end else if (present) begin
        end else if (freeK >= 0) begin
          sUsed[m][freeK] = 1; sNode[m][freeK] = n;
        end else if (m == 0) begin
          mOvf[m] = 1;
        end else if (m == 1) begin
          eValid[m] = 1; eEv[m] = 1; eEvN[m] = sNode[m][mRr[m]];
          eMask[m][eEvN[m]] = 1'b1;
          sNode[m][mRr[m]] = n;
          mRr[m] = (mRr[m] + 1) % PTRS;
        end else begin
          mCov[m] = grpMask(n);
          for (int k = 0; k < PTRS; k++) begin
            mCov[m] |= grpMask(sNode[m][k]);
            sUsed[m][k] = 0;
          end
          mOvf[m] = 1;
        end
      end
      1: begin
        if (!mOvf[m])
          for (int k = 0; k < PTRS; k++) if (sUsed[m][k] && sNode[m][k] == n) sUsed[m][k] = 0;
      end
      2: begin
        if (mOvf[m]) t = (m == 0) ? '1 : mCov[m];
        else for (int k = 0; k < PTRS; k++) if (sUsed[m][k]) t[sNode[m][k]] = 1'b1;
        t[n] = 1'b0;
        eValid[m] = 1; eMask[m] = t; eAll[m] = mOvf[m] && (m == 0);
        for (int k = 0; k < PTRS; k++) sUsed[m][k] = 0;
        sUsed[m][0] = 1; sNode[m][0] = n;
        mOvf[m] = 0; mCov[m] = '0;
      end
      default: ;
    endcase
  endtask

  task automatic checkMode(input int m, input string tag);
    vectors++;
    if (invValidV[m] !== eValid[m] || invAllV[m] !== eAll[m] || invMaskV[m] !== eMask[m] ||
        evictValidV[m] !== eEv[m] || (eEv[m] && evictNodeV[m] !== NW'(eEvN[m]))) begin
      misses++;
      $display("FAIL %s policy %0d: actual v=%0b all=%0b mask=%h ev=%0b evn=%0d, expected v=%0b all=%0b mask=%h ev=%0b evn=%0d",
               tag, m, invValidV[m], invAllV[m], invMaskV[m], evictValidV[m], evictNodeV[m],
               eValid[m], eAll[m], eMask[m], eEv[m], eEvN[m]);
    end
  endtask

  // drive on a falling edge, compare on the next falling edge
  task automatic step(input int op, input int n, input string tB, input string tE, input string tC);
    cmdValid = (op != 3);
    cmdOp    = 2'(op);
    cmdNode  = NW'(n);
    for (int m = 0; m < 3; m++) modelStep(m, op, n);
    @(negedge clk);
    checkMode(0, tB);
    checkMode(1, tE);
    checkMode(2, tC);
    cmdValid = 1'b0;
    cmdOp    = 2'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL R2 watchdog: actual run still busy, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int r;
    modelReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 3; m++) checkMode(m, "R1");

    // exact pointer form
    step(0, 3,  "R3", "R3", "R3");
    step(0, 9,  "R3", "R3", "R3");
    step(0, 3,  "R3", "R3", "R3");
    step(2, 5,  "R3", "R3", "R3");
    step(2, 7,  "R10", "R10", "R10");
    step(3, 0,  "R2", "R2", "R2");
    step(0, 2,  "R2", "R2", "R2");
    step(1, 2,  "R4", "R4", "R4");
    step(1, 11, "R4", "R4", "R4");
    step(2, 7,  "R4", "R4", "R4");

    // overflow per policy
    step(0, 4,  "R3", "R3", "R3");
    step(0, 12, "R5", "R6", "R7");
    step(0, 0,  "R5", "R6", "R7");
    step(1, 12, "R9", "R4", "R9");
    step(2, 4,  "R5", "R11", "R8");
    step(2, 9,  "R10", "R10", "R10");

    // second overflow round: victim index continues, groups accumulate
    step(0, 1,  "R3", "R3", "R3");
    step(0, 14, "R5", "R6", "R7");
    step(0, 15, "R5", "R6", "R7");
    step(0, 6,  "R5", "R6", "R7");
    step(2, 15, "R11", "R11", "R8");

    // mixed traffic biased toward adds
    for (int i = 0; i < 800; i++) begin
      r = $urandom_range(0, 9);
      step((r < 6) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3, $urandom_range(0, NODES - 1),
           "R11", "R11", "R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule